// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a serial slave port that gives an external controller read and write access to a bank of sixteen 5-bit command registers. The controller frames each transaction with an active-high chip select and clocks 16 bits through it on a serial clock. The first eight bits form a header: a direction flag, a 4-bit register address sent least significant bit first, two reserved bits that must be zero, and one ignored bit. The remaining eight clock cycles carry the data.

A write delivers eight data bits and keeps the low five of them. A read returns a 5-bit word. The returned bits change on falling clock edges, so the controller can sample each one on the following rising edge. The serial output has its own drive enable, and that enable is asserted only while read data is being returned. This lets the data-in and data-out lines share one wire at the pad. The surrounding logic can see the whole bank at once through a parallel output.

Top module: `ser_reg_slave`

## Requirements
- R1: While `rst_n` is low, all sixteen registers clear to zero and `sdo_oe` is low.
- R2: Frame cycles are counted on the rising edges of `sclk` while `cs` is high. Cycle 1 samples the direction flag, where 1 means read and 0 means write. Cycles 2 to 5 sample address bits 0 to 3, lowest bit first. `cs` must be low on at least one rising edge between frames.
- R3: On a write, data bits 0 to 7 are sampled on cycles 9 to 16, lowest bit first. On the rising edge of cycle 16, bits 0 to 4 are stored in the addressed register and bits 5 to 7 are discarded.
- R4: On a read, `sdo_oe` goes high at the falling edge of cycle 8. Register bits 0 to 4 appear on `sdo` at the falling edges of cycles 8 to 12, so each is valid at the rising edges of cycles 9 to 13.
- R5: `sdo_oe` is low at every other time. That includes the whole of a write frame, the read cycles after bit 4, and any moment `cs` is low, with the drop following `cs` immediately.
- R6: If either reserved bit (cycles 6 and 7) is 1, a write changes no register. A read in that case returns all zeros while `sdo_oe` still follows R4.
- R7: The bit sampled on cycle 8 has no effect on reads or writes.
- R8: If `cs` falls before the rising edge of cycle 16, no register changes.
- R9: Rising edges after cycle 16 within the same frame are ignored: they cause no further write and no output drive.
- R10: `regs_o` shows register i on bits [5i+4:5i] at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock |
| rst_n | input | 1 | Active-low asynchronous reset of the bank and port state |
| cs | input | 1 | Active-high chip select framing a transaction |
| sdi | input | 1 | Serial data in, sampled on rising edges |
| sdo | output | 1 | Serial data out, updated on falling edges |
| sdo_oe | output | 1 | Pad drive enable for `sdo` |
| regs_o | output | 80 | Parallel view of all registers |

## Verification
Random frames mix reads and writes over all addresses and data bytes, so a wrong bit order, a swapped address bit or a leaked upper data bit shows up as a mismatch with the bench's register model. Some random frames set a reserved bit; these separate a reserved-bit discard from a normal write or read. Some random frames end early or run long; these separate an aborted or over-long frame from a completed one. Directed frames fix the hard corners: the all-ones byte truncated to five bits, a read with the ignored bit set, an abort at cycle 12 carrying a write, and the exact enable window checked cycle by cycle on every frame.

// File: rtl/ser_reg_slave.sv
`timescale 1ns/1ps
module ser_reg_slave #(
  parameter int AW = 4,
  parameter int DW = 5,
  parameter int WW = 8
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  output logic [(1<<AW)*DW-1:0] regs_o
);
  localparam int NREG  = 1 << AW;
  localparam int HDR   = AW + 4;
  localparam int FRAME = HDR + WW;
  localparam int CW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] C_HDR   = CW'(HDR);
  localparam logic [CW-1:0] C_RDEND = CW'(HDR + DW);
  localparam logic [CW-1:0] C_LAST  = CW'(FRAME - 1);
  localparam logic [CW-1:0] C_FRAME = CW'(FRAME);
  localparam logic [CW-1:0] C_AW    = CW'(AW);

  logic [CW-1:0] cnt;
  logic          rw_q, bad_q, oe_q, dout_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wlo;
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] rd_word;

  assign rd_word = regs[addr_q];

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rw_q   <= 1'b0;
      bad_q  <= 1'b0;
      addr_q <= '0;
      wlo    <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (!cs) begin
      cnt <= '0;
    end else begin
      if (cnt != C_FRAME) cnt <= cnt + 1'b1;
      if (cnt == '0) begin
        rw_q  <= sdi;
        bad_q <= 1'b0;
      end
      if (cnt >= 1 && cnt <= C_AW) addr_q[$clog2(AW)'(cnt - 1'b1)] <= sdi;
      if (cnt == C_AW + 1'b1 || cnt == C_AW + 2'd2) bad_q <= bad_q | sdi;
      if (cnt >= C_HDR && cnt < C_RDEND) wlo[$clog2(DW)'(cnt - C_HDR)] <= sdi;
      if (cnt == C_LAST && !rw_q && !bad_q) regs[addr_q] <= wlo;
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      dout_q <= 1'b0;
    end else if (cs && rw_q && cnt >= C_HDR && cnt < C_RDEND) begin
      oe_q   <= 1'b1;
      dout_q <= bad_q ? 1'b0 : rd_word[$clog2(DW)'(cnt - C_HDR)];
    end else begin
      oe_q   <= 1'b0;
    end
  end

  assign sdo_oe = oe_q & cs;
  assign sdo    = oe_q & cs & dout_q;

  for (genvar g = 0; g < NREG; g++) begin : g_view
    assign regs_o[g*DW +: DW] = regs[g];
  end

  a_r5_drive_window: assert property (@(posedge sclk) disable iff (!rst_n)
    (cs && oe_q) |-> (rw_q && cnt >= C_HDR && cnt < C_RDEND));
  a_r3_write_only_at_end: assert property (@(posedge sclk) disable iff (!rst_n)
    !(cs && cnt == C_LAST && !rw_q && !bad_q) |=> $stable(regs_o));
  a_r6_reserved_blocks: assert property (@(posedge sclk) disable iff (!rst_n)
    (cs && cnt == C_LAST && bad_q) |=> $stable(regs_o));
  a_r8_abort_clears: assert property (@(posedge sclk) disable iff (!rst_n)
    !cs |=> cnt == '0);
  a_r9_count_bound: assert property (@(posedge sclk) disable iff (!rst_n)
    cnt <= C_FRAME);
endmodule

// File: tb/ser_reg_slave_tb.sv
`timescale 1ns/1ps
module ser_reg_slave_tb_top;
  logic sclk = 1'b0, rst_n = 1'b0, cs = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [79:0] regs_o;
  logic [4:0] model [16];
  int checks = 0, errors = 0;

  always #2.5 sclk = ~sclk;

  ser_reg_slave dut_i (.sclk(sclk), .rst_n(rst_n), .cs(cs), .sdi(sdi),
                       .sdo(sdo), .sdo_oe(sdo_oe), .regs_o(regs_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [79:0] model_flat();
    logic [79:0] f;
    for (int i = 0; i < 16; i++) f[i*5 +: 5] = model[i];
    return f;
  endfunction

  function automatic logic [4:0] exp_read(input logic [3:0] a, input logic [1:0] rsv);
    return (rsv != 2'b00) ? 5'd0 : model[a];
  endfunction

  task automatic xfer(input logic rw, input logic [3:0] a, input logic [1:0] rsv,
                      input logic a6, input logic [7:0] d, input int len, input string tag);
    logic [4:0] rd = '0;
    logic [4:0] er = exp_read(a, rsv);
    int oe_bad = 0;
    for (int k = 1; k <= len; k++) begin
      logic b;
      @(negedge sclk); #1;
      cs = 1'b1;
      if (k == 1) b = rw;
      else if (k <= 5) b = a[k-2];
      else if (k == 6) b = rsv[0];
      else if (k == 7) b = rsv[1];
      else if (k == 8) b = a6;
      else if (k <= 16) b = d[k-9];
      else b = 1'($urandom);
      sdi = b;
      #1;
      if (sdo_oe !== (rw && k >= 9 && k <= 13)) oe_bad++;
      if (k >= 9 && k <= 13) rd[k-9] = sdo;
    end
    chk({tag, " R4/R5 enable window"}, oe_bad, 0);
    if (rw && len >= 13) chk({tag, " R4 read data"}, rd, er);
    @(negedge sclk); #1;
    cs = 1'b0; sdi = 1'b0;
    #0.5;
    chk({tag, " R5 enable off with cs low"}, sdo_oe, 0);
    @(negedge sclk); #1;
    if (!rw && rsv == 2'b00 && len >= 16) model[a] = d[4:0];
    chk({tag, " R10 parallel view"}, regs_o, model_flat());
  endtask

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) model[i] = '0;
    #1;
    chk("R1 regs clear in reset", regs_o, 80'd0);
    chk("R1 enable low in reset", sdo_oe, 0);
    repeat (3) @(negedge sclk);
    rst_n = 1'b1;
    @(negedge sclk);
    xfer(0, 4'd15, 2'b00, 0, 8'hFF, 16, "R3 all-ones truncation");
    chk("R3 upper bits dropped", regs_o[79:75], 5'h1F);
    xfer(0, 4'd1, 2'b00, 0, 8'h0A, 16, "R2 addr 1");
    xfer(0, 4'd8, 2'b00, 0, 8'h15, 16, "R2 addr 8");
    chk("R2 address order", {regs_o[9:5], regs_o[44:40]}, {5'h0A, 5'h15});
    xfer(1, 4'd15, 2'b00, 0, 8'h00, 16, "R4 read reg15");
    xfer(1, 4'd8, 2'b00, 1, 8'h00, 16, "R7 read with ignored bit set");
    xfer(0, 4'd3, 2'b00, 1, 8'h13, 16, "R7 write with ignored bit set");
    xfer(0, 4'd1, 2'b01, 0, 8'h1F, 16, "R6 reserved write ignored");
    xfer(0, 4'd1, 2'b10, 0, 8'h1F, 16, "R6 reserved write ignored");
    xfer(1, 4'd15, 2'b10, 0, 8'h00, 16, "R6 reserved read zeros");
    xfer(0, 4'd2, 2'b00, 0, 8'h1B, 12, "R8 abort at 12");
    chk("R8 reg2 unchanged", regs_o[14:10], 5'd0);
    xfer(1, 4'd15, 2'b00, 0, 8'h00, 11, "R8 abort mid-read");
    xfer(0, 4'd4, 2'b00, 0, 8'h07, 20, "R9 long write");
    xfer(1, 4'd4, 2'b00, 0, 8'h00, 20, "R9 long read");
    for (int n = 0; n < 300; n++) begin
      logic rw = 1'($urandom);
      logic [3:0] a = 4'($urandom);
      logic [1:0] rsv = ($urandom % 8 == 0) ? 2'($urandom % 3 + 1) : 2'b00;
      logic a6 = 1'($urandom);
      logic [7:0] d = 8'($urandom);
      int r = $urandom % 10;
      int len = (r == 0) ? 1 + $urandom % 15 : (r == 1) ? 17 + $urandom % 4 : 16;
      xfer(rw, a, rsv, a6, d, len, "random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule